// File: doc/BRIEF.md
# High-Speed Idle Suspend/Reset Discriminator

This controller lives in the link layer of a USB device that can run at high speed. It watches a digitised line state from the transceiver, together with a flag that reports high-speed bus activity. While the device runs at high speed, the block times how long the bus stays quiet without a break. When that quiet period reaches the idle threshold, the block takes the transceiver back to full-speed operation and turns the full-speed pull-up on again.

After a short settle interval, the block reads the full-speed line to find out what the host wants. A single-ended zero means the host is driving a bus Reset. In that case the block pulses a request that starts the high-speed detection handshake. An idle (J) line means the host is asking for Suspend, so the block raises its suspend flag. If the line shows neither state, a watchdog forces the suspend decision once the total idle time reaches the limit. While suspended, resume signalling (K) returns the block straight to high-speed mode.

All durations come from a cycles-per-microsecond parameter and three microsecond counts. A bench can therefore shrink the 3 ms, 100 us and 10 ms windows to a few dozen cycles.

Top module: `hs_idle_discriminator`

## Requirements
- R1: After a synchronous reset, hsMode is 0, pullupEn is 1, suspended is 0 and chirpStart is 0.
- R2: While in full-speed operation and not suspended, a high chirpDone moves the block to high-speed mode on the next edge. At that point hsMode is 1 and pullupEn is 0.
- R3: In high-speed mode, hsMode falls and pullupEn rises on the clock edge that samples the IDLE_CYC-th consecutive cycle with hsActive low. hsMode does not fall any earlier. IDLE_CYC is CYCLES_PER_US times IDLE_US.
- R4: Any cycle with hsActive high in high-speed mode restarts the idle count from zero, and high-speed mode is kept.
- R5: For SETTLE_CYC cycles after the switch to full speed, the line state is ignored. SETTLE_CYC is CYCLES_PER_US times SETTLE_US. During that window neither chirpStart nor suspended can be produced, even while the line shows SE0.
- R6: After the settle window, a lineState of 2'b00 (SE0) produces chirpStart high for exactly one cycle. The block then stays at full speed with the pull-up on and is not suspended.
- R7: After the settle window, a lineState of 2'b01 (J, idle) sets suspended. The pull-up stays on and hsMode stays low.
- R8: After the settle window, a lineState of 2'b10 (K) or 2'b11 (SE1) leaves the decision open. If the decision is still open when the idle time counted from the first idle cycle reaches LIMIT_CYC cycles, suspended is forced on that edge. LIMIT_CYC is CYCLES_PER_US times LIMIT_US.
- R9: While suspended, a lineState of 2'b10 (K, resume) restores high-speed mode on the next edge: hsMode goes to 1, pullupEn to 0 and suspended to 0. Any other line state keeps suspended.

Ports table, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lineState | input | 2 | Line state code: 00 SE0, 01 J, 10 K, 11 SE1 |
| hsActive | input | 1 | High-speed bus activity seen (non-idle) |
| chirpDone | input | 1 | The high-speed detection handshake finished successfully |
| hsMode | output | 1 | Select high-speed transceiver mode |
| pullupEn | output | 1 | Enable the full-speed pull-up |
| suspended | output | 1 | Device is in Suspend |
| chirpStart | output | 1 | One-cycle pulse that starts the high-speed detection handshake |

## Verification
The hardest case to reach from the ports is the watchdog path. Here classification stays open until the total idle time runs out. That requires high-speed mode, a full idle threshold with no activity, the whole settle window, and then a line that sits at K so that neither normal classification path can finish. The bench builds the DUT with scaled timing (30, 5 and 60 cycles). It holds the line at K through the whole idle period and checks suspended one cycle before and on the exact limit edge. A line held at SE0 through the settle window shows that the transient is ignored.

// File: rtl/hsidle_pkg.sv
package hsidle_pkg;

  typedef enum logic [1:0] {
    LINE_SE0 = 2'b00,
    LINE_J   = 2'b01,
    LINE_K   = 2'b10,
    LINE_SE1 = 2'b11
  } line_e;

  typedef enum logic [2:0] {
    ST_FULL,
    ST_HIGH,
    ST_SETTLE,
    ST_CLASSIFY,
    ST_SUSPEND
  } mode_e;

  // strobes from control to the timer datapath
  typedef struct packed {
    logic idleClr;
    logic idleInc;
    logic settleClr;
    logic settleInc;
  } ctlStrobe_t;

  // terminal-count flags from the datapath back to control
  typedef struct packed {
    logic idleHit;
    logic settleHit;
    logic limitHit;
  } dpFlags_t;

endpackage

// File: rtl/hsidle_timers.sv
module hsidle_timers
  import hsidle_pkg::*;
#(
  parameter int IDLE_CYC   = 180000,
  parameter int SETTLE_CYC = 6000,
  parameter int LIMIT_CYC  = 600000
) (
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t strobe,
  output dpFlags_t   flags
);

  localparam int IDLE_W   = $clog2(LIMIT_CYC + 1);
  localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);
  localparam logic [IDLE_W-1:0]   IDLE_LAST   = IDLE_W'(IDLE_CYC - 1);
  localparam logic [IDLE_W-1:0]   LIMIT_LAST  = IDLE_W'(LIMIT_CYC - 1);
  localparam logic [SETTLE_W-1:0] SETTLE_LAST = SETTLE_W'(SETTLE_CYC - 1);

  logic [IDLE_W-1:0]   idleCnt;
  logic [SETTLE_W-1:0] settleCnt;

  // total idle time since the last high-speed activity
  always_ff @(posedge clk) begin
    if (rst || strobe.idleClr) begin
      idleCnt <= '0;
    end else if (strobe.idleInc && (idleCnt != LIMIT_LAST)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // time since the switch back to full speed
  always_ff @(posedge clk) begin
    if (rst || strobe.settleClr) begin
      settleCnt <= '0;
    end else if (strobe.settleInc && (settleCnt != SETTLE_LAST)) begin
      settleCnt <= settleCnt + 1'b1;
    end
  end

  always_comb begin
    flags.idleHit   = (idleCnt == IDLE_LAST);
    flags.limitHit  = (idleCnt == LIMIT_LAST);
    flags.settleHit = (settleCnt == SETTLE_LAST);
  end

endmodule

// File: rtl/hsidle_fsm.sv
module hsidle_fsm
  import hsidle_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lineState,
  input  logic       hsActive,
  input  logic       chirpDone,
  input  dpFlags_t   flags,
  output ctlStrobe_t strobe,
  output logic       hsMode,
  output logic       pullupEn,
  output logic       suspended,
  output logic       chirpStart
);

  mode_e state, stateNext;
  logic  chirpNext;
  line_e line;

  assign line = line_e'(lineState);

  always_comb begin
    stateNext = state;
    chirpNext = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_FULL: begin
        strobe.idleClr   = 1'b1;
        strobe.settleClr = 1'b1;
        if (chirpDone) stateNext = ST_HIGH;
      end
      ST_HIGH: begin
        strobe.settleClr = 1'b1;
        if (hsActive) begin
          strobe.idleClr = 1'b1;
        end else begin
          strobe.idleInc = 1'b1;
          if (flags.idleHit) stateNext = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        // line is not looked at here: transceiver still settling
        strobe.idleInc   = 1'b1;
        strobe.settleInc = 1'b1;
        if (flags.settleHit) stateNext = ST_CLASSIFY;
      end
      ST_CLASSIFY: begin
        strobe.idleInc   = 1'b1;
        strobe.settleClr = 1'b1;
        if (line == LINE_SE0) begin
          stateNext = ST_FULL;
          chirpNext = 1'b1;
        end else if (line == LINE_J || flags.limitHit) begin
          stateNext = ST_SUSPEND;
        end
      end
      ST_SUSPEND: begin
        strobe.idleClr   = 1'b1;
        strobe.settleClr = 1'b1;
        if (line == LINE_K) stateNext = ST_HIGH;
      end
      default: begin
        stateNext = ST_FULL;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_FULL;
      chirpStart <= 1'b0;
    end else begin
      state      <= stateNext;
      chirpStart <= chirpNext;
    end
  end

  always_comb begin
    hsMode    = (state == ST_HIGH);
    pullupEn  = (state != ST_HIGH);
    suspended = (state == ST_SUSPEND);
  end

endmodule

// File: rtl/hs_idle_discriminator.sv
module hs_idle_discriminator
  import hsidle_pkg::*;
#(
  parameter int CYCLES_PER_US = 60,
  parameter int IDLE_US       = 3000,
  parameter int SETTLE_US     = 100,
  parameter int LIMIT_US      = 10000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lineState,
  input  logic       hsActive,
  input  logic       chirpDone,
  output logic       hsMode,
  output logic       pullupEn,
  output logic       suspended,
  output logic       chirpStart
);

  localparam int IDLE_CYC   = CYCLES_PER_US * IDLE_US;
  localparam int SETTLE_CYC = CYCLES_PER_US * SETTLE_US;
  localparam int LIMIT_CYC  = CYCLES_PER_US * LIMIT_US;

  generate
    if (SETTLE_CYC < 1 || IDLE_CYC < 1) begin : g_badTiming
      $error("idle and settle windows must be at least one cycle");
    end
    if (LIMIT_CYC <= IDLE_CYC + SETTLE_CYC) begin : g_badLimit
      $error("suspend limit must exceed idle threshold plus settle window");
    end
  endgenerate

  ctlStrobe_t strobe;
  dpFlags_t   flags;

  hsidle_timers #(
    .IDLE_CYC  (IDLE_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .LIMIT_CYC (LIMIT_CYC)
  ) u_timers (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .flags (flags)
  );

  hsidle_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .lineState (lineState),
    .hsActive  (hsActive),
    .chirpDone (chirpDone),
    .flags     (flags),
    .strobe    (strobe),
    .hsMode    (hsMode),
    .pullupEn  (pullupEn),
    .suspended (suspended),
    .chirpStart(chirpStart)
  );

endmodule

// File: rtl/hsidle_checker.sv
module hsidle_checker #(
  parameter int IDLE_CYC = 180000
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] lineState,
  input logic       hsActive,
  input logic       hsMode,
  input logic       pullupEn,
  input logic       suspended,
  input logic       chirpStart
);

  logic        rstQ = 1'b0;
  int unsigned idleRun;

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst) idleRun <= 0;
    else if (hsMode) idleRun <= hsActive ? 0 : idleRun + 1;
    else idleRun <= 0;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rstQ |-> (!hsMode && pullupEn && !suspended && !chirpStart));

  p_exit_after_idle_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(hsMode) |-> (idleRun == IDLE_CYC));

  p_activity_keeps_hs_r4: assert property (@(posedge clk) disable iff (rst)
    (hsMode && hsActive) |=> hsMode);

  p_chirp_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    chirpStart |=> !chirpStart);

  p_chirp_after_se0_r6: assert property (@(posedge clk) disable iff (rst)
    chirpStart |-> ($past(lineState) == 2'b00 && !hsMode && pullupEn));

  p_suspend_full_speed_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(suspended) |-> (pullupEn && !hsMode && !chirpStart));

  p_resume_to_hs_r9: assert property (@(posedge clk) disable iff (rst)
    (suspended && lineState == 2'b10) |=> (hsMode && !pullupEn && !suspended));

  p_stay_suspended_r9: assert property (@(posedge clk) disable iff (rst)
    (suspended && lineState != 2'b10) |=> suspended);

endmodule

bind hs_idle_discriminator hsidle_checker #(.IDLE_CYC(IDLE_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lineState (lineState),
  .hsActive  (hsActive),
  .hsMode    (hsMode),
  .pullupEn  (pullupEn),
  .suspended (suspended),
  .chirpStart(chirpStart)
);

// File: tb/tb_hs_idle_discriminator.sv
`timescale 1ns/1ps
module tb_hs_idle_discriminator;

  localparam int IDLE   = 30;
  localparam int SETTLE = 5;
  localparam int LIMIT  = 60;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] lineState;
  logic       hsActive;
  logic       chirpDone;
  logic       hsMode, pullupEn, suspended, chirpStart;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hs_idle_discriminator #(
    .CYCLES_PER_US(1),
    .IDLE_US      (IDLE),
    .SETTLE_US    (SETTLE),
    .LIMIT_US     (LIMIT)
  ) dut (
    .clk(clk), .rst(rst), .lineState(lineState), .hsActive(hsActive),
    .chirpDone(chirpDone), .hsMode(hsMode), .pullupEn(pullupEn),
    .suspended(suspended), .chirpStart(chirpStart)
  );

  // classify vectors: [5:4] line, [3] chirpStart, [2] suspended, [1] hsMode, [0] pullupEn
  localparam logic [5:0] VECS [4] = '{
    6'b00_1_0_0_1,   // SE0 -> reset handshake request (R6)
    6'b01_0_1_0_1,   // J   -> suspend (R7)
    6'b10_0_0_0_1,   // K   -> undecided (R8)
    6'b11_0_0_0_1    // SE1 -> undecided (R8)
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; hsActive = 1'b1; chirpDone = 1'b0; lineState = 2'b01;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic enterHs();
    chirpDone = 1'b1;
    tick(1);
    chirpDone = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1", "hsMode", hsMode, 1'b0);
    check("R1", "pullupEn", pullupEn, 1'b1);
    check("R1", "suspended", suspended, 1'b0);
    check("R1", "chirpStart", chirpStart, 1'b0);

    // R2 enter high speed
    enterHs();
    check("R2", "hsMode", hsMode, 1'b1);
    check("R2", "pullupEn", pullupEn, 1'b0);

    // R3 threshold edge, with SE0 present as a transient
    hsActive = 1'b0; lineState = 2'b00;
    tick(IDLE - 1);
    check("R3", "hsMode before threshold", hsMode, 1'b1);
    tick(1);
    check("R3", "hsMode at threshold", hsMode, 1'b0);
    check("R3", "pullupEn at threshold", pullupEn, 1'b1);

    // R5 SE0 during settle ignored
    tick(SETTLE - 1);
    check("R5", "chirpStart in settle", chirpStart, 1'b0);
    check("R5", "suspended in settle", suspended, 1'b0);
    lineState = 2'b01;
    tick(1);
    check("R5", "chirpStart at settle end", chirpStart, 1'b0);
    tick(1);
    check("R7", "suspended on J", suspended, 1'b1);

    // R9 stays suspended on J, resumes on K
    tick(3);
    check("R9", "suspended holds", suspended, 1'b1);
    lineState = 2'b10;
    tick(1);
    check("R9", "hsMode after resume", hsMode, 1'b1);
    check("R9", "pullupEn after resume", pullupEn, 1'b0);
    check("R9", "suspended after resume", suspended, 1'b0);

    // R4 activity restarts the idle count
    hsActive = 1'b0;
    tick(IDLE - 1);
    hsActive = 1'b1;
    tick(1);
    hsActive = 1'b0;
    tick(IDLE - 1);
    check("R4", "hsMode after restart", hsMode, 1'b1);
    tick(1);
    check("R4", "hsMode after full idle", hsMode, 1'b0);

    // vector table: classification outcomes (R6, R7, R8)
    for (int v = 0; v < 4; v++) begin
      doReset();
      enterHs();
      hsActive = 1'b0; lineState = 2'b00;
      tick(IDLE + SETTLE);
      lineState = VECS[v][5:4];
      tick(1);
      check(v == 0 ? "R6" : (v == 1 ? "R7" : "R8"), "chirpStart", chirpStart, VECS[v][3]);
      check(v == 0 ? "R6" : (v == 1 ? "R7" : "R8"), "suspended", suspended, VECS[v][2]);
      check(v == 0 ? "R6" : (v == 1 ? "R7" : "R8"), "hsMode", hsMode, VECS[v][1]);
      check(v == 0 ? "R6" : (v == 1 ? "R7" : "R8"), "pullupEn", pullupEn, VECS[v][0]);
      if (v == 0) begin
        tick(1);
        check("R6", "chirpStart one cycle", chirpStart, 1'b0);
        check("R6", "suspended after reset request", suspended, 1'b0);
      end
    end

    // R8 watchdog forces suspend at the limit edge
    doReset();
    enterHs();
    hsActive = 1'b0; lineState = 2'b10;
    tick(LIMIT - 1);
    check("R8", "suspended before limit", suspended, 1'b0);
    tick(1);
    check("R8", "suspended at limit", suspended, 1'b1);

    // R1 reset from suspend
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    check("R1", "suspended after reset", suspended, 1'b0);
    check("R1", "pullupEn after reset", pullupEn, 1'b1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule